// File: doc/BRIEF.md
# 64-bit Single-Error-Correcting, Double-Error-Detecting Memory Codec

This block protects a 64-bit memory data word with 8 check bits. On the write side it turns a data word into its check byte, which is stored next to the data. On the read side it takes the returned data word and its stored check byte and recomputes the check byte from the data. It combines the two into an 8-bit syndrome and sorts the read into one of three cases: clean, repaired single-bit error, or uncorrectable error.

The code uses odd-weight columns, each of them distinct. The syndrome is compared against the column of every one of the 72 stored bits. A syndrome that equals a data column flips that data bit before the word is returned. A syndrome that equals a check-bit column is also a repaired single-bit error, but the data needs no change. Any other non-zero syndrome is reported as uncorrectable, whether its weight is even or odd, and the raw data is passed through without a guess at a repair. The write path is combinational. The read result, the syndrome and the status are registered, with a valid strobe one cycle behind the read strobe.

Top module: `ecc_secded_codec`

## Requirements
- R1: The write check byte `wr_check[r]` is the XOR of every `wr_data[j]` whose column has bit r set. The columns of data bits 0..63 are built in two steps. First, take all byte values of weight 3 in ascending order, followed by byte values of weight 5 in ascending order, and keep the first 64. Second, exchange the entry at index 17 with the entry that holds 0x52. Check bit i has column 1<<i.
- R2: The column of data bit 17 is 0x52. A read of a correctly encoded word with only data bit 17 inverted yields syndrome 0x52 and returns the original word.
- R3: A zero syndrome gives status CLEAN (2'b00), and the read data is returned unchanged.
- R4: A syndrome equal to the column of data bit j gives status FIXED (2'b01), and the returned word is the read word with bit j inverted.
- R5: A syndrome equal to the column of check bit i (one-hot) gives status FIXED (2'b01), and the data is returned unchanged.
- R6: Any two stored bits inverted together give a non-zero syndrome of even weight, status FATAL (2'b10), and the raw read data.
- R7: A non-zero syndrome of odd weight that matches no column (for example 0x5B or 0x7F) gives status FATAL (2'b10) and the raw read data.
- R8: `out_valid` equals `rd_valid` of the previous cycle. The syndrome, status and data outputs load only in cycles with `rd_valid` high and hold otherwise.
- R9: After reset, `out_valid` is 0, `out_data` and `out_syndrome` are zero, and `out_status` is CLEAN.
- R10: `out_status` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Data word to be stored |
| wr_check | output | 8 | Check byte for `wr_data` (combinational) |
| rd_valid | input | 1 | A read word is present this cycle |
| rd_data | input | 64 | Data word returned by memory |
| rd_check | input | 8 | Check byte returned by memory |
| out_valid | output | 1 | Registered result valid |
| out_data | output | 64 | Corrected (or raw, if uncorrectable) read word |
| out_syndrome | output | 8 | Syndrome of the captured read |
| out_status | output | 2 | 00 clean, 01 single-bit fixed, 10 uncorrectable |

## Verification
The write check byte has no register in its path, so the bench compares it a short delay after it drives `wr_data`, within the same cycle. Read inputs are driven on a falling edge and pass through one output register. The bench therefore compares data, syndrome, status and valid at the next falling edge, after exactly one rising edge. For the hold behaviour, the bench lowers the read strobe, changes the read inputs and compares one falling edge later. The sweeps cover every single-bit position, every bit pair and all 256 syndrome values, and the bench classifies each of them from its own independently built column table.

// File: rtl/ecc_codec_pkg.sv
package ecc_codec_pkg;

  localparam int DATA_W  = 64;
  localparam int CHK_W   = 8;
  localparam int CW_W    = DATA_W + CHK_W;
  localparam int PIN_IDX = 17;
  localparam logic [CHK_W-1:0] PIN_COL = 8'h52;

  typedef logic [DATA_W-1:0][CHK_W-1:0] col_tbl_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } ecc_status_e;

  function automatic int popcnt(input logic [CHK_W-1:0] v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  // Odd-weight column table: weight 3 ascending, then weight 5 ascending,
  // with the pinned column moved to the pinned data position.
  function automatic col_tbl_t build_cols();
    col_tbl_t t;
    int n;
    int pin_at;
    logic [CHK_W-1:0] tmp;
    t = '0;
    n = 0;
    pin_at = -1;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 1; v < (1 << CHK_W); v++) begin
        if (n < DATA_W && popcnt(v[CHK_W-1:0]) == w) begin
          t[n] = v[CHK_W-1:0];
          n++;
        end
      end
    end
    for (int k = 0; k < DATA_W; k++) begin
      if (t[k] == PIN_COL) pin_at = k;
    end
    if (pin_at >= 0) begin
      tmp        = t[PIN_IDX];
      t[PIN_IDX] = t[pin_at];
      t[pin_at]  = tmp;
    end
    return t;
  endfunction

  // Data bits feeding check bit r.
  function automatic logic [DATA_W-1:0] row_sel(input col_tbl_t t, input int r);
    logic [DATA_W-1:0] s;
    for (int j = 0; j < DATA_W; j++) s[j] = t[j][r];
    return s;
  endfunction

endpackage

// File: rtl/ecc_check_gen.sv
module ecc_check_gen
  import ecc_codec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);

  localparam col_tbl_t H = build_cols();

  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    localparam logic [DATA_W-1:0] SEL = row_sel(H, r);
    assign check[r] = ^(data & SEL);
  end

endmodule

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import ecc_codec_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  stored,
  output logic [CHK_W-1:0]  syndrome
);

  logic [CHK_W-1:0] recomputed;

  ecc_check_gen u_regen (
    .data  (data),
    .check (recomputed)
  );

  assign syndrome = recomputed ^ stored;

endmodule

// File: rtl/ecc_syn_decode.sv
module ecc_syn_decode
  import ecc_codec_pkg::*;
(
  input  logic [CHK_W-1:0]  syndrome,
  input  logic [DATA_W-1:0] raw_data,
  output logic [CW_W-1:0]   col_hit,
  output logic              fix_hit,
  output logic              fatal,
  output logic [DATA_W-1:0] fixed_data
);

  localparam col_tbl_t H = build_cols();

  logic [DATA_W-1:0] flip_mask;

  for (genvar j = 0; j < DATA_W; j++) begin : g_dcol
    assign col_hit[j] = (syndrome == H[j]);
  end

  for (genvar i = 0; i < CHK_W; i++) begin : g_ccol
    localparam logic [CHK_W-1:0] ONE = CHK_W'(1) << i;
    assign col_hit[DATA_W+i] = (syndrome == ONE);
  end

  assign flip_mask  = col_hit[DATA_W-1:0];
  assign fix_hit    = |col_hit;
  assign fatal      = (syndrome != '0) && !fix_hit;
  assign fixed_data = fatal ? raw_data : (raw_data ^ flip_mask);

endmodule

// File: rtl/ecc_secded_codec.sv
module ecc_secded_codec
  import ecc_codec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       wr_data,
  output logic [7:0]        wr_check,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  input  logic [7:0]        rd_check,
  output logic              out_valid,
  output logic [63:0]       out_data,
  output logic [7:0]        out_syndrome,
  output logic [1:0]        out_status
);

  logic [CHK_W-1:0]  rd_syn;
  logic [CW_W-1:0]   rd_col_hit;
  logic              rd_fix_hit;
  logic              rd_fatal;
  logic [DATA_W-1:0] rd_fixed;
  ecc_status_e       status_nxt;

  ecc_check_gen u_wr_gen (
    .data  (wr_data),
    .check (wr_check)
  );

  ecc_syndrome u_rd_syn (
    .data     (rd_data),
    .stored   (rd_check),
    .syndrome (rd_syn)
  );

  ecc_syn_decode u_rd_dec (
    .syndrome   (rd_syn),
    .raw_data   (rd_data),
    .col_hit    (rd_col_hit),
    .fix_hit    (rd_fix_hit),
    .fatal      (rd_fatal),
    .fixed_data (rd_fixed)
  );

  always_comb begin
    if (rd_fatal)        status_nxt = ST_FATAL;
    else if (rd_fix_hit) status_nxt = ST_FIXED;
    else                 status_nxt = ST_CLEAN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_syndrome <= '0;
      out_status   <= ST_CLEAN;
    end else begin
      out_valid <= rd_valid;
      if (rd_valid) begin
        out_data     <= rd_fixed;
        out_syndrome <= rd_syn;
        out_status   <= status_nxt;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> ($stable(out_data) && $stable(out_syndrome) && $stable(out_status))); // R8
  AST_CLEAN_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == ST_CLEAN) |-> (out_syndrome == '0)); // R3
  AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_fix_hit) |-> ($countones(rd_col_hit) == 1)); // R4
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ($countones(out_data ^ $past(rd_data)) <= 1)); // R4
  AST_FATAL_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_fatal) |=> (out_data == $past(rd_data) && out_status == ST_FATAL)); // R6
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_status != 2'b11); // R10

endmodule

// File: tb/ecc_secded_codec_bench.sv
`timescale 1ns/1ps
module ecc_secded_codec_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_check;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_check = '0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_syndrome;
  logic [1:0]  out_status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] col [64];

  always #2.5 clk = ~clk;

  ecc_secded_codec u_ecc_secded_codec (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
    .out_valid(out_valid), .out_data(out_data),
    .out_syndrome(out_syndrome), .out_status(out_status)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Column table rebuilt with triple bit loops for weight 3.
  task automatic make_cols();
    int n;
    int p;
    logic [7:0] t;
    n = 0;
    for (int c = 2; c < 8; c++)
      for (int b = 1; b < c; b++)
        for (int a = 0; a < b; a++) begin
          col[n] = (8'd1 << a) | (8'd1 << b) | (8'd1 << c);
          n++;
        end
    for (int v = 0; v < 256 && n < 64; v++) begin
      if ($countones(v[7:0]) == 5) begin
        col[n] = v[7:0];
        n++;
      end
    end
    p = 0;
    for (int k = 0; k < 64; k++) if (col[k] == 8'h52) p = k;
    t = col[17]; col[17] = col[p]; col[p] = t;
  endtask

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [7:0] c;
    c = '0;
    for (int j = 0; j < 64; j++) if (d[j]) c ^= col[j];
    return c;
  endfunction

  task automatic check_write(input logic [63:0] d);
    wr_data = d;
    #1;
    chk(wr_check == enc(d), "R1 write check", {56'd0, wr_check}, {56'd0, enc(d)});
  endtask

  // Drive at a falling edge, compare at the next falling edge.
  task automatic read_cmp(input logic [63:0] d, input logic [7:0] c, input string req);
    logic [7:0]  s;
    logic [1:0]  st;
    logic [63:0] ed;
    s  = enc(d) ^ c;
    st = 2'b10;
    ed = d;
    if (s == 8'h00) st = 2'b00;
    for (int j = 0; j < 64; j++) if (s == col[j]) begin st = 2'b01; ed = d ^ (64'd1 << j); end
    for (int i = 0; i < 8; i++) if (s == (8'd1 << i)) st = 2'b01;
    rd_valid = 1'b1; rd_data = d; rd_check = c;
    @(negedge clk);
    chk(out_valid === 1'b1, {req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(out_syndrome === s, {req, " syndrome"}, {56'd0, out_syndrome}, {56'd0, s});
    chk(out_status === st, {req, " status"}, {62'd0, out_status}, {62'd0, st});
    chk(out_data === ed, {req, " data"}, out_data, ed);
  endtask

  logic [63:0] pats [6];

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    make_cols();
    pats[0] = 64'h1234_5678_9ABC_DEF0; pats[1] = 64'h0;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF; pats[3] = 64'hA5A5_5A5A_0F0F_F0F0;
    pats[4] = 64'h8000_0000_0000_0001; pats[5] = 64'hDEAD_BEEF_CAFE_F00D;
    #1;
    // R9 reset state
    chk(out_valid === 1'b0, "R9 valid", {63'd0, out_valid}, 64'd0);
    chk(out_data === 64'd0, "R9 data", out_data, 64'd0);
    chk(out_syndrome === 8'd0, "R9 syndrome", {56'd0, out_syndrome}, 64'd0);
    chk(out_status === 2'b00, "R9 status", {62'd0, out_status}, 64'd0);
    #20;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R1 write path
    for (int k = 0; k < 6; k++) check_write(pats[k]);
    for (int k = 0; k < 64; k++) check_write(64'd1 << k);
    for (int k = 0; k < 200; k++) check_write({$urandom, $urandom});

    // R2 pinned column at bit 17
    chk(col[17] == 8'h52, "R2 column", {56'd0, col[17]}, 64'h52);
    read_cmp(pats[0] ^ (64'd1 << 17), enc(pats[0]), "R2 bit17");
    chk(out_syndrome === 8'h52 && out_data === pats[0], "R2 pinned", out_data, pats[0]);

    // R3 clean reads
    for (int k = 0; k < 6; k++) read_cmp(pats[k], enc(pats[k]), "R3 clean");

    // R4 / R5 single-bit flips on every stored bit
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 64; j++) read_cmp(pats[k] ^ (64'd1 << j), enc(pats[k]), "R4 data flip");
      for (int i = 0; i < 8; i++) read_cmp(pats[k], enc(pats[k]) ^ (8'd1 << i), "R5 check flip");
    end

    // R6 every pair of stored bits
    for (int a = 0; a < 72; a++)
      for (int b = a + 1; b < 72; b++) begin
        logic [71:0] m;
        m = (72'd1 << a) | (72'd1 << b);
        read_cmp(pats[5] ^ m[63:0], enc(pats[5]) ^ m[71:64], "R6 double");
        chk(out_status === 2'b10, "R6 fatal", {62'd0, out_status}, 64'd2);
      end

    // R7 / R10 exhaustive syndrome sweep
    for (int s = 0; s < 256; s++) begin
      read_cmp(pats[3], enc(pats[3]) ^ s[7:0], "R7 sweep");
      chk(out_status !== 2'b11, "R10 legal", {62'd0, out_status}, 64'd0);
    end
    read_cmp(pats[4], enc(pats[4]) ^ 8'h5B, "R7 0x5B");
    chk(out_status === 2'b10 && out_data === pats[4], "R7 0x5B fatal", out_data, pats[4]);
    read_cmp(pats[4], enc(pats[4]) ^ 8'h7F, "R7 0x7F");
    chk(out_status === 2'b10, "R7 0x7F fatal", {62'd0, out_status}, 64'd2);

    // R8 idle hold
    read_cmp(pats[2] ^ 64'd4, enc(pats[2]), "R8 load");
    rd_valid = 1'b0; rd_data = pats[1]; rd_check = 8'hFF;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 valid low", {63'd0, out_valid}, 64'd0);
    chk(out_data === pats[2], "R8 data hold", out_data, pats[2]);
    chk(out_status === 2'b01, "R8 status hold", {62'd0, out_status}, 64'd1);
    @(negedge clk);
    chk(out_data === pats[2], "R8 data hold 2", out_data, pats[2]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule